// File: doc/BRIEF.md
# Serial converter capture controller

This block runs inside a fast synchronous system clock domain and operates a 12-bit serial successive-approximation converter. It drives the converter's convert strobe and a gated serial clock, and it assembles the returned bits into a parallel word. A host pulses `start` together with a read mode and a power-saving enable. The controller then waits until the strobe has been high long enough to acquire the input. It drops the strobe to begin the conversion and clocks the conversion out. When the word is complete it returns the word with a one-cycle valid pulse.

The read mode decides how the strobe is shaped inside each conversion. Normal mode reads the most significant bit first. Reverse mode raises and then lowers the strobe around the end of the conversion, so the converter repeats the bits lowest first. Short mode stops the conversion early after a programmable number of bits. The serial clock divide ratio and the acquisition length are parameters in system clock cycles. Elaboration stops if either of them breaks the converter's minimum timing at the given system clock period.

Top module: `adc_cap_ctrl`

## Requirements
- R1: After reset, `adc_conv` is high, `adc_sclk` is low, `busy` and `result_valid` are low, and `result` is zero.
- R2: The strobe falls to start a conversion only after it has been high for at least `ACQ_CYC` system cycles (350 ns or more). The first serial clock rising edge follows the fall after `SCLK_HALF_CYC` cycles, which is well within 5 µs.
- R3: Each serial clock phase lasts `SCLK_HALF_CYC` system cycles, so each phase is at least 50 ns and each period at least 125 ns. The serial clock is parked low whenever no conversion is running.
- R4: The strobe changes state only one system cycle after a serial clock rising edge or while the serial clock is parked. This keeps at least 10 ns between any strobe change and any serial clock falling edge.
- R5: The word is sampled at serial clock rising edges, and the bit taken at rising edge k (k = 2..13) is data bit 13-k, so bit 11 comes first. In normal mode (`mode` = 2'b00) the conversion uses 13 serial clocks and `result` equals the converted word.
- R6: In normal mode with `pd_en` high, the strobe stays low through the 13th serial clock, which lets the converter power down. With `pd_en` low, the strobe rises during the 11th serial clock.
- R7: In reverse mode (`mode` = 2'b01), the strobe rises during serial clock 12 and falls during serial clock 13. 24 serial clocks are issued, and rising edges 14..24 carry data bits 1..11. `result` equals the converted word.
- R8: In short mode (`mode` = 2'b10), the bit count N is `short_bits` clamped to the range 1..10. The strobe rises during clock N+1, after the last needed bit has been taken, and falls during clock N+2. N+2 clocks are issued. `result` holds the N captured bits in its upper positions and zeros below them.
- R9: `result_valid` is a single-cycle pulse at the end of a conversion, and `busy` is low in that same cycle. `result` keeps its value until the next conversion completes.
- R10: A `start` pulse while `busy` is high is ignored. It starts no second conversion and does not change the mode in use.
- R11: `mode` = 2'b11 behaves exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled when idle |
| mode | input | 2 | Read mode: 00 normal, 01 reverse, 10 short, 11 normal |
| short_bits | input | 4 | Bit count for short mode (clamped to 1..10) |
| pd_en | input | 1 | Power down between samples in normal mode |
| adc_dout | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sclk | output | 1 | Gated serial clock to the converter |
| result | output | 12 | Last assembled word |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |
| busy | output | 1 | High from an accepted start until completion |

## Verification
The bench builds the block with a 4 ns system period, 16-cycle serial clock phases (128 ns period) and an 88-cycle acquisition (352 ns). Both timings sit just above the converter's minimums, so the bench's converter model measures every strobe and clock edge against those limits. The short slice of the serial clock keeps each conversion under a thousand cycles. This makes it possible to sweep every `short_bits` code from 0 to 15, both power-down settings in the normal modes and a set of edge-pattern words in every mode.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int RES_W = 12;

  typedef enum logic [1:0] {
    RD_NORMAL  = 2'b00,
    RD_REVERSE = 2'b01,
    RD_SHORT   = 2'b10,
    RD_ALIAS   = 2'b11
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_RUN,
    ST_TAIL
  } cap_state_e;
endpackage

// File: rtl/adc_cap_sclk_gen.sv
module adc_cap_sclk_gen #(
  parameter int HALF_CYC = 16,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt    <= '0;
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (cnt == LAST) begin
        cnt    <= '0;
        sclk_o <= ~sclk_o;
        if (!sclk_o) begin
          rise_o <= 1'b1;
          idx_o  <= idx_o + 1'b1;
        end else begin
          fall_o <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !sclk_o); // R3
endmodule

// File: rtl/adc_cap_acq_timer.sv
module adc_cap_acq_timer #(
  parameter int ACQ_CYC = 88
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_i,
  input  logic arm_i,
  output logic ok_o
);
  localparam int CW = $clog2(ACQ_CYC + 1);
  localparam logic [CW-1:0] DONE = CW'(ACQ_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !conv_i) cnt <= '0;
    else if (cnt != DONE) cnt <= cnt + 1'b1;
  end

  assign ok_o = (cnt == DONE);

  AST_ACQ_MET: assert property (@(posedge clk) disable iff (rst)
    ($fell(conv_i) && $past(arm_i)) |-> $past(ok_o)); // R2
endmodule

// File: rtl/adc_cap_assembler.sv
module adc_cap_assembler #(
  parameter int W  = 12,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [PW-1:0] pos_i,
  input  logic          din_i,
  output logic [W-1:0]  word_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) word_o <= '0;
    else if (cap_i) word_o[pos_i] <= din_i;
  end
endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int SYS_NS        = 4,
  parameter int SCLK_HALF_CYC = 16,
  parameter int ACQ_CYC       = 88
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [3:0]       short_bits,
  input  logic             pd_en,
  input  logic             adc_dout,
  output logic             adc_conv,
  output logic             adc_sclk,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             busy
);
  localparam int IDX_W  = $clog2(2 * RES_W + 3);
  localparam int POS_W  = $clog2(RES_W);
  localparam int TCW    = $clog2(SCLK_HALF_CYC + 1);
  localparam int NB_MAX = RES_W - 2;
  localparam logic [IDX_W-1:0] K_NORM_LAST = IDX_W'(RES_W + 1);
  localparam logic [IDX_W-1:0] K_REV_LAST  = IDX_W'(2 * RES_W);
  localparam logic [IDX_W-1:0] K_NORM_UP   = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] K_REV_UP    = IDX_W'(RES_W);
  localparam logic [IDX_W-1:0] K_REV_DN    = IDX_W'(RES_W + 1);
  localparam logic [TCW-1:0]   TAIL_END    = TCW'(SCLK_HALF_CYC - 1);

  if (SCLK_HALF_CYC * SYS_NS < 50 || 2 * SCLK_HALF_CYC * SYS_NS < 125) begin : g_bad_sclk
    $error("serial clock phase or period below converter minimum");
  end
  if (ACQ_CYC * SYS_NS < 350) begin : g_bad_acq
    $error("acquisition window below converter minimum");
  end
  if (SCLK_HALF_CYC * SYS_NS > 5000) begin : g_bad_droop
    $error("first serial clock too late after strobe fall");
  end

  cap_state_e       state;
  rd_mode_e         mode_q;
  logic             pd_q;
  logic [POS_W-1:0] nb_q;
  logic [POS_W-1:0] nb_in;
  logic             last_seen;
  logic [TCW-1:0]   tail_cnt;

  logic             rise, fall, acq_ok;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] k_last, k_up, k_dn, k_nb1;
  logic             cap_en;
  logic [IDX_W-1:0] pos_wide;
  logic [RES_W-1:0] word;

  always_comb begin
    if (short_bits == '0) nb_in = POS_W'(1);
    else if (short_bits > 4'(NB_MAX)) nb_in = POS_W'(NB_MAX);
    else nb_in = POS_W'(short_bits);
  end

  always_comb begin
    k_nb1 = IDX_W'(nb_q) + IDX_W'(1);
    unique case (mode_q)
      RD_REVERSE: begin k_last = K_REV_LAST;  k_up = K_REV_UP; k_dn = K_REV_DN; end
      RD_SHORT:   begin k_last = k_nb1 + 1'b1; k_up = k_nb1;    k_dn = k_nb1 + 1'b1; end
      default:    begin k_last = K_NORM_LAST; k_up = pd_q ? '0 : K_NORM_UP; k_dn = '0; end
    endcase
  end

  always_comb begin
    cap_en   = 1'b0;
    pos_wide = '0;
    if (idx >= IDX_W'(2) && idx <= K_NORM_LAST &&
        (mode_q != RD_SHORT || idx <= k_nb1)) begin
      cap_en   = 1'b1;
      pos_wide = K_NORM_LAST - idx;
    end else if (mode_q == RD_REVERSE && idx > K_NORM_LAST && idx <= K_REV_LAST) begin
      cap_en   = 1'b1;
      pos_wide = idx - K_NORM_LAST;
    end
  end

  adc_cap_sclk_gen #(.HALF_CYC(SCLK_HALF_CYC), .IDX_W(IDX_W)) u_sclk (
    .clk(clk), .rst(rst), .run_i(state == ST_RUN),
    .sclk_o(adc_sclk), .rise_o(rise), .fall_o(fall), .idx_o(idx)
  );

  adc_cap_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk(clk), .rst(rst), .conv_i(adc_conv), .arm_i(state == ST_ACQ), .ok_o(acq_ok)
  );

  adc_cap_assembler #(.W(RES_W), .PW(POS_W)) u_asm (
    .clk(clk), .rst(rst),
    .clr_i(state == ST_IDLE && start),
    .cap_i(state == ST_RUN && rise && cap_en),
    .pos_i(POS_W'(pos_wide)), .din_i(adc_dout), .word_o(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mode_q       <= RD_NORMAL;
      pd_q         <= 1'b0;
      nb_q         <= POS_W'(1);
      adc_conv     <= 1'b1;
      busy         <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
      last_seen    <= 1'b0;
      tail_cnt     <= '0;
    end else begin
      result_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q <= rd_mode_e'(mode);
          pd_q   <= pd_en;
          nb_q   <= nb_in;
          busy   <= 1'b1;
          state  <= ST_ACQ;
        end
        ST_ACQ: if (acq_ok) begin
          adc_conv  <= 1'b0;
          last_seen <= 1'b0;
          state     <= ST_RUN;
        end
        ST_RUN: begin
          if (rise) begin
            if (idx == k_up) adc_conv <= 1'b1;
            if (idx == k_dn) adc_conv <= 1'b0;
            if (idx == k_last) last_seen <= 1'b1;
          end
          if (fall && last_seen) begin
            tail_cnt <= '0;
            state    <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          tail_cnt <= tail_cnt + 1'b1;
          if (tail_cnt == TAIL_END) begin
            adc_conv     <= 1'b1;
            result       <= word;
            result_valid <= 1'b1;
            busy         <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !adc_sclk); // R3
  AST_CONV_CLEAR_OF_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> $stable(adc_conv)); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R9
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R10
endmodule

// File: tb/sim_adc_cap_ctrl.sv
`timescale 1ns/1ps
module sim_adc_cap_ctrl;
  localparam int RW = 12;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, pd_en = 1'b0, adc_dout = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] short_bits = 4'd0;
  logic adc_conv, adc_sclk, result_valid, busy;
  logic [RW-1:0] result;

  always #2 clk = ~clk;

  adc_cap_ctrl #(.SYS_NS(4), .SCLK_HALF_CYC(16), .ACQ_CYC(88)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .short_bits(short_bits),
    .pd_en(pd_en), .adc_dout(adc_dout), .adc_conv(adc_conv), .adc_sclk(adc_sclk),
    .result(result), .result_valid(result_valid), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model state
  logic [RW-1:0] word = '0;
  int falls = 0, rises = 0, convs = 0;
  bit in_conv = 0, lsb_seen = 0, abort_seen = 0, pd_seen = 0, rose_in = 0;
  realtime t_crise = 0, t_cfall = 0, t_sfall = -100, t_sedge = 0, t_cchg = -100;

  initial begin
    logic pc, ps;
    wait (!rst);
    pc = adc_conv;
    ps = adc_sclk;
    forever begin
      @(adc_conv or adc_sclk);
      if (adc_conv !== pc) begin
        pc = adc_conv;
        chk($realtime - t_sfall >= 10.0, "R4 strobe hold after clock fall",
            int'($realtime - t_sfall), 10);
        t_cchg = $realtime;
        if (adc_conv) begin
          t_crise = $realtime;
          if (in_conv) rose_in = 1;
        end else if (in_conv && falls == RW && rose_in && !lsb_seen) begin
          lsb_seen = 1;
        end else if (in_conv && falls < RW && rose_in) begin
          abort_seen = 1;
          in_conv = 0;
          adc_dout = 1'b0;
        end else begin
          chk($realtime - t_crise >= 350.0, "R2 acquisition time",
              int'($realtime - t_crise), 350);
          convs++;
          in_conv = 1; falls = 0; rises = 0;
          lsb_seen = 0; abort_seen = 0; pd_seen = 0; rose_in = 0;
          t_cfall = $realtime;
          adc_dout = 1'b0;
        end
      end
      if (adc_sclk !== ps) begin
        ps = adc_sclk;
        if (adc_sclk && rises == 0) begin
          chk($realtime - t_cfall <= 5000.0 && $realtime - t_cfall >= 50.0,
              "R2 first clock delay", int'($realtime - t_cfall), 64);
        end else begin
          chk($realtime - t_sedge >= 50.0, "R3 clock phase width",
              int'($realtime - t_sedge), 64);
        end
        t_sedge = $realtime;
        if (adc_sclk) begin
          rises++;
        end else begin
          chk($realtime - t_cchg >= 10.0, "R4 strobe setup before clock fall",
              int'($realtime - t_cchg), 10);
          t_sfall = $realtime;
          falls++;
          if (in_conv && falls == RW && !adc_conv) pd_seen = 1;
          if (!in_conv) adc_dout = 1'b0;
          else if (falls >= 1 && falls <= RW) adc_dout = word[RW - falls];
          else if (lsb_seen && falls <= 2 * RW - 1) adc_dout = word[falls - RW];
          else adc_dout = 1'b0;
        end
      end
    end
  end

  task automatic run_one(input logic [1:0] m, input int nb, input bit pd,
                         input logic [RW-1:0] w, input string tag);
    int nbc, exp_rises, waited;
    logic [RW-1:0] exp_r;
    bit exp_pd, exp_lsb, exp_abort;
    nbc = (nb < 1) ? 1 : (nb > 10 ? 10 : nb);
    exp_pd = 0; exp_lsb = 0; exp_abort = 0;
    case (m)
      2'b01: begin exp_r = w; exp_rises = 2 * RW; exp_lsb = 1; end
      2'b10: begin
        exp_r = w & ~((RW'(1) << (RW - nbc)) - RW'(1));
        exp_rises = nbc + 2; exp_abort = 1;
      end
      default: begin exp_r = w; exp_rises = RW + 1; exp_pd = pd; end
    endcase
    word = w;
    @(negedge clk);
    mode = m; short_bits = 4'(nb); pd_en = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!result_valid && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(result_valid, {tag, " completion"}, waited, 0);
    chk(result == exp_r, {tag, " result word"}, int'(result), int'(exp_r));
    chk(!busy, "R9 busy low with valid", int'(busy), 0);
    chk(rises == exp_rises, {tag, " serial clock count"}, rises, exp_rises);
    chk(pd_seen == exp_pd, "R6 power-down strobe shape", int'(pd_seen), int'(exp_pd));
    chk(lsb_seen == exp_lsb, "R7 reverse readback strobe", int'(lsb_seen), int'(exp_lsb));
    chk(abort_seen == exp_abort, "R8 early stop strobe", int'(abort_seen), int'(exp_abort));
    @(negedge clk);
    chk(!result_valid, "R9 valid single cycle", int'(result_valid), 0);
    repeat (5) @(negedge clk);
    chk(result == exp_r, "R9 result held", int'(result), int'(exp_r));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] pats [6];
    int c0;
    pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'h800;
    pats[3] = 12'h001; pats[4] = 12'hA5A; pats[5] = 12'h5A5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(adc_conv === 1'b1, "R1 strobe high", int'(adc_conv), 1);
    chk(adc_sclk === 1'b0, "R1 clock low", int'(adc_sclk), 0);
    chk(busy === 1'b0, "R1 busy low", int'(busy), 0);
    chk(result_valid === 1'b0, "R1 valid low", int'(result_valid), 0);
    chk(result === '0, "R1 result zero", int'(result), 0);

    for (int i = 0; i < 6; i++) begin
      run_one(2'b00, 0, 1'b0, pats[i], "R5");
      run_one(2'b00, 0, 1'b1, pats[i], "R6");
      run_one(2'b01, 0, 1'b0, pats[i], "R7");
    end
    for (int i = 0; i < 4; i++) begin
      run_one(2'b01, 0, 1'b1, RW'(i * 12'h9A7 + 12'h135), "R7");
      run_one(2'b11, 0, i[0], RW'(i * 12'h3C9 + 12'h2E1), "R11");
    end
    for (int n = 0; n < 16; n++) begin
      run_one(2'b10, n, 1'b0, 12'hFFF, "R8");
      run_one(2'b10, n, 1'b1, RW'(n * 12'h1D3 + 12'hB6C), "R8");
    end

    // R10: start during busy is ignored
    c0 = convs;
    word = 12'h6C3;
    @(negedge clk);
    mode = 2'b00; pd_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    chk(busy, "R10 busy during conversion", int'(busy), 1);
    mode = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 2'b00;
    while (!result_valid) @(negedge clk);
    chk(result == 12'h6C3, "R10 result unchanged", int'(result), 'h6C3);
    chk(rises == RW + 1, "R10 mode kept", rises, RW + 1);
    repeat (1000) @(negedge clk);
    chk(!busy, "R10 no second conversion busy", int'(busy), 0);
    chk(convs == c0 + 1, "R10 conversion count", convs, c0 + 1);
    chk(adc_conv && !adc_sclk, "R3 parked after run", int'(adc_sclk), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule